// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block is the interrupt logic beside a small 8-bit processor core. It keeps one 8-bit control and status register. The register holds a master enable, one enable for each of two sources and one latched request flag for each source. The two sources are an external pin event and a timer overflow. Each request pulse latches its flag. The flag stays set until the source is served or software clears it.

The core raises a phase strobe once per instruction cycle. Service is only decided in the cycle where the strobe is high. On that edge the controller takes the higher-priority source that is pending and enabled, provided the master enable is set and the return stack has room. It then sends the core a one-cycle call request with the fixed 12-bit vector of that source. In the same edge it drops the master enable and the served flag, so no second handler can nest. A return-from-interrupt pulse turns the master enable back on. A plain subroutine return pulse does not. Software can also turn it back on by writing the register.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and callReq is low.
- R2: Register fields are: bit 0 master enable, bit 1 external enable, bit 2 timer enable, bit 4 external flag, bit 5 timer flag. A write with regWe updates all five fields from regWdata on the next edge. Bits 3, 6 and 7 always read 0. regRdata is combinational from the register.
- R3: A pulse on extReq or tmrReq sets its flag (reads 1) whatever the enables are. The flag stays set until it is served or written to 0.
- R4: Service is decided only on an edge where phaseStb is high, using the register contents from before that edge. callReq is high for exactly the one cycle after that edge. A request that arrives on the same edge as a strobe is therefore served at the next strobe.
- R5: If both sources are pending and enabled, the external source wins with callVec 0x004. The timer source uses callVec 0x008.
- R6: On a grant edge, the master enable and the served flag clear. The other flag is kept.
- R7: No grant occurs while the master enable is 0 or while the pending source's own enable is 0. Flags still latch in that state.
- R8: No grant occurs while stackFull is high. The flag stays latched and is served on the first strobe after stackFull falls.
- R9: retiPulse sets the master enable. retPulse leaves it unchanged.
- R10: If a request pulse and a register write that clears the same flag arrive on the same edge, the flag ends up set.
- R11: A software write that sets the master enable and a source enable resumes service of a latched flag on the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseStb | input | 1 | Instruction-cycle phase strobe |
| extReq | input | 1 | External interrupt request pulse (already synchronised) |
| tmrReq | input | 1 | Timer overflow request pulse |
| regWe | input | 1 | Register write enable |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| retiPulse | input | 1 | Return-from-interrupt executed |
| retPulse | input | 1 | Plain subroutine return executed |
| stackFull | input | 1 | Return stack has no free entry |
| callReq | output | 1 | One-cycle call request to the core |
| callVec | output | 12 | Handler address, valid while callReq is high |

## Verification
Directed sequences cover four cases. A lone external request tests the basic grant and the flag and enable clearing. Both requests latched together test priority, and show that the losing flag survives the first grant. Strobes with the master enable off, with a source enable off and with the stack full show that each of the three blockers stops service on its own. A request coinciding with a strobe is told apart from one that arrives between strobes, and a write that collides with a request checks which side wins. A random phase then drives every input at once. A behavioural model checks the register value and the call outputs on every clock.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int NSRC    = 2;
  localparam int SRC_EXT = 0;
  localparam int SRC_TMR = 1;

  typedef struct packed {
    logic ackTmr;
    logic ackExt;
  } irq_strobe_t;
endpackage

// File: rtl/vec_irq_regfile.sv
module vec_irq_regfile
  import vec_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   reqIn,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              retiPulse,
  input  logic              retPulse,
  input  irq_strobe_t       stb,
  output logic              gieQ,
  output logic [NSRC-1:0]   enQ,
  output logic [NSRC-1:0]   flagQ,
  output logic [REG_W-1:0]  regRdata
);
  localparam int GIE_BIT   = 0;
  localparam int EN_BASE   = 1;
  localparam int FLAG_BASE = 4;

  logic [NSRC-1:0] ackVec;
  logic            ackAny;

  assign ackVec = {stb.ackTmr, stb.ackExt};
  assign ackAny = |ackVec;

  // master enable: grant beats return-from-interrupt beats software write
  always_ff @(posedge clk) begin
    if (!rstN)          gieQ <= 1'b0;
    else if (ackAny)    gieQ <= 1'b0;
    else if (retiPulse) gieQ <= 1'b1;
    else if (regWe)     gieQ <= regWdata[GIE_BIT];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN)          enQ[i] <= 1'b0;
      else if (regWe)     enQ[i] <= regWdata[EN_BASE+i];
    end

    // hardware set beats grant clear beats software write
    always_ff @(posedge clk) begin
      if (!rstN)          flagQ[i] <= 1'b0;
      else if (reqIn[i])  flagQ[i] <= 1'b1;
      else if (ackVec[i]) flagQ[i] <= 1'b0;
      else if (regWe)     flagQ[i] <= regWdata[FLAG_BASE+i];
    end

    p_hw_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
      reqIn[i] |=> flagQ[i]);

    p_flag_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ackVec[i] && !reqIn[i]) |=> !flagQ[i]);
  end

  always_comb begin
    regRdata = '0;
    regRdata[GIE_BIT] = gieQ;
    for (int k = 0; k < NSRC; k++) begin
      regRdata[EN_BASE+k]   = enQ[k];
      regRdata[FLAG_BASE+k] = flagQ[k];
    end
  end

  p_reti_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retiPulse && !ackAny) |=> gieQ);

  p_ret_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && !retiPulse && !regWe && !ackAny) |=> $stable(gieQ));

  p_ack_masks_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackAny |=> !gieQ);
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import vec_irq_pkg::*;
#(
  parameter int               VEC_W   = 12,
  parameter logic [VEC_W-1:0] EXT_VEC = 12'h004,
  parameter logic [VEC_W-1:0] TMR_VEC = 12'h008
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseStb,
  input  logic              stackFull,
  input  logic              gie,
  input  logic [NSRC-1:0]   en,
  input  logic [NSRC-1:0]   flag,
  output irq_strobe_t       stb,
  output logic              callReq,
  output logic [VEC_W-1:0]  callVec
);
  logic [NSRC-1:0] pend;
  logic            grant;

  assign pend  = flag & en;
  assign grant = phaseStb && gie && !stackFull && (|pend);

  always_comb begin
    stb        = '0;
    stb.ackExt = grant && pend[SRC_EXT];
    stb.ackTmr = grant && !pend[SRC_EXT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      callReq <= 1'b0;
      callVec <= '0;
    end else begin
      callReq <= grant;
      if (grant) callVec <= pend[SRC_EXT] ? EXT_VEC : TMR_VEC;
    end
  end

  p_call_on_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $past(phaseStb));

  p_single_call_r6: assert property (@(posedge clk) disable iff (!rstN)
    callReq |=> !callReq);

  p_stack_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> !$past(stackFull));

  p_ext_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && callVec == TMR_VEC) |-> !$past(pend[SRC_EXT]));

  p_masked_r7: assert property (@(posedge clk) disable iff (!rstN)
    !gie |=> !callReq);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int               REG_W   = 8,
  parameter int               VEC_W   = 12,
  parameter logic [VEC_W-1:0] EXT_VEC = 12'h004,
  parameter logic [VEC_W-1:0] TMR_VEC = 12'h008
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseStb,
  input  logic             extReq,
  input  logic             tmrReq,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             retiPulse,
  input  logic             retPulse,
  input  logic             stackFull,
  output logic             callReq,
  output logic [VEC_W-1:0] callVec
);
  irq_strobe_t     stb;
  logic            gieQ;
  logic [NSRC-1:0] enQ;
  logic [NSRC-1:0] flagQ;
  logic [NSRC-1:0] reqIn;

  always_comb begin
    reqIn          = '0;
    reqIn[SRC_EXT] = extReq;
    reqIn[SRC_TMR] = tmrReq;
  end

  vec_irq_regfile #(.REG_W(REG_W)) i_regfile (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWe(regWe), .regWdata(regWdata),
    .retiPulse(retiPulse), .retPulse(retPulse), .stb(stb),
    .gieQ(gieQ), .enQ(enQ), .flagQ(flagQ), .regRdata(regRdata)
  );

  vec_irq_arbiter #(.VEC_W(VEC_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) i_arbiter (
    .clk(clk), .rstN(rstN), .phaseStb(phaseStb), .stackFull(stackFull),
    .gie(gieQ), .en(enQ), .flag(flagQ), .stb(stb),
    .callReq(callReq), .callVec(callVec)
  );
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseStb = 1'b0, extReq = 1'b0, tmrReq = 1'b0;
  logic        regWe = 1'b0, retiPulse = 1'b0, retPulse = 1'b0, stackFull = 1'b0;
  logic [7:0]  regWdata = 8'h00;
  logic [7:0]  regRdata;
  logic        callReq;
  logic [11:0] callVec;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .phaseStb(phaseStb), .extReq(extReq), .tmrReq(tmrReq),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .retiPulse(retiPulse), .retPulse(retPulse), .stackFull(stackFull),
    .callReq(callReq), .callVec(callVec)
  );

  // behavioural reference model
  bit mGie, mEe, mTe, mEf, mTf, mCall;
  int mVec;

  always @(posedge clk) begin
    bit ack, selExt;
    if (!rstN) begin
      {mGie, mEe, mTe, mEf, mTf, mCall} = '0;
      mVec = 0;
    end else begin
      selExt = mEf && mEe;
      ack = phaseStb && mGie && !stackFull && (selExt || (mTf && mTe));
      mCall = ack;
      if (ack) mVec = selExt ? 4 : 8;
      if (ack) mGie = 0; else if (retiPulse) mGie = 1; else if (regWe) mGie = regWdata[0];
      if (extReq) mEf = 1; else if (ack && selExt) mEf = 0; else if (regWe) mEf = regWdata[4];
      if (tmrReq) mTf = 1; else if (ack && !selExt) mTf = 0; else if (regWe) mTf = regWdata[5];
      if (regWe) begin mEe = regWdata[1]; mTe = regWdata[2]; end
    end
  end

  function automatic logic [7:0] modelReg();
    return {2'b00, mTf, mEf, 1'b0, mTe, mEe, mGie};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 model register", regRdata, modelReg());
      chk("R4 model callReq", callReq, mCall);
      if (callReq && mCall) chk("R5 model callVec", callVec, mVec);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    extReq = 0; tmrReq = 0; regWe = 0; retiPulse = 0; retPulse = 0; phaseStb = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    regWe = 1; regWdata = d; step();
  endtask

  task automatic strobe();
    phaseStb = 1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset call", callReq, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset reg", regRdata, 8'h00);
    chk("R1 reset call", callReq, 0);

    wr(8'hFF);
    chk("R2 unused bits read 0", regRdata, 8'h37);
    wr(8'h00);
    chk("R2 write clears", regRdata, 8'h00);

    extReq = 1; step();
    chk("R3 flag latches disabled", regRdata, 8'h10);
    strobe();
    chk("R7 no call master off", callReq, 0);
    step();
    chk("R3 flag held", regRdata, 8'h10);

    wr(8'h17);
    chk("R4 no call without strobe", callReq, 0);
    step();
    chk("R4 no call without strobe", callReq, 0);
    strobe();
    chk("R4 call after strobe", callReq, 1);
    chk("R5 ext vector", callVec, 12'h004);
    chk("R6 gie and flag cleared", regRdata, 8'h06);
    step();
    chk("R4 call one cycle", callReq, 0);

    extReq = 1; tmrReq = 1; step();
    chk("R3 both flags", regRdata, 8'h36);
    retPulse = 1; step();
    chk("R9 ret keeps gie", regRdata, 8'h36);
    retiPulse = 1; step();
    chk("R9 reti sets gie", regRdata, 8'h37);
    strobe();
    chk("R5 ext wins", callVec, 12'h004);
    chk("R6 other flag kept", regRdata, 8'h26);
    strobe();
    chk("R6 nesting blocked", callReq, 0);
    retiPulse = 1; step();
    strobe();
    chk("R5 tmr call", callReq, 1);
    chk("R5 tmr vector", callVec, 12'h008);
    chk("R6 tmr flag cleared", regRdata, 8'h06);

    tmrReq = 1; step();
    retiPulse = 1; step();
    stackFull = 1; strobe();
    chk("R8 stack full blocks", callReq, 0);
    chk("R8 flag held", regRdata, 8'h27);
    stackFull = 0; strobe();
    chk("R8 served after room", callReq, 1);
    chk("R8 vector", callVec, 12'h008);

    wr(8'h01);
    extReq = 1; step();
    strobe();
    chk("R7 source enable off", callReq, 0);
    chk("R7 flag latched", regRdata, 8'h11);
    wr(8'h13);
    strobe();
    chk("R11 write resumes", callReq, 1);
    chk("R11 vector", callVec, 12'h004);

    extReq = 1; regWe = 1; regWdata = 8'h00; step();
    chk("R10 hw set wins", regRdata, 8'h10);

    wr(8'h03);
    extReq = 1; phaseStb = 1; step();
    chk("R4 same edge not served", callReq, 0);
    chk("R4 flag set", regRdata, 8'h13);
    strobe();
    chk("R4 served next strobe", callReq, 1);

    for (int n = 0; n < 2000; n++) begin
      int r = $urandom_range(0, 99);
      phaseStb  = (n % 4) == 0;
      extReq    = r < 8;
      tmrReq    = (r % 7) == 0;
      retiPulse = (r > 85);
      retPulse  = (r % 11) == 0;
      stackFull = (r % 9) == 0;
      regWe     = (r > 95);
      regWdata  = 8'($urandom);
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule